// File: doc/BRIEF.md
# Acquisition Sync Trigger Generator

This block produces the pulse that starts a digitizer acquisition. A start event comes from one of two places: an already-decoded beam-sync start-event match, or a turn scaler that counts turn markers down and fires each time it passes zero. Start selection can also be switched off. A trigger is then taken from one of three places: the start event itself, a pre-trigger counter started by that event, or an external trigger pin that is synchronised on chip. Trigger selection can also be switched off.

An accepted trigger starts a delay timer counted in RF clock periods. When the delay expires, the block drives a sync pulse of fixed width. In single mode the block disarms after one pulse and waits for a new arm strobe. In repetitive mode every following turn marker starts the delay again. Two one-cycle strobes mark the start of the delay timer and the end of its count, and can be used as interrupt sources. Decoding of the serial event streams is done outside this block.

Top module: `acq_sync_gen`

## Requirements
- R1: After reset, `sync_out`, `irq_dly_trig` and `irq_dly_tc` are low and the block is disarmed. No trigger produces a pulse until `arm` has been pulsed.
- R2: `start_sel` selects the start event. 2'b00 uses `start_match`. 2'b10 uses the turn scaler. 2'b01 and 2'b11 give no start. Pulsing `arm` loads the scaler with `turn_scale`. Each `turn_mark` then decrements the scaler, and a mark that finds the scaler at zero is a start event and reloads the scaler. So the (L+1)-th mark after arming starts the sequence, where L is `turn_scale`.
- R3: `trig_sel` selects the trigger source. 0 is the pre-trigger path, 1 is the external input, 2 is the start event directly, and 3 gives no trigger.
- R4: With `trig_sel`=0 and `pretrig_en`=1, the trigger follows the start event by `pretrig_dly`+1 clocks. With `pretrig_en`=0, the trigger arrives in the same clock as the start event.
- R5: `ext_trig` passes through two synchroniser flops and an edge detector. A rise driven in cycle n gives a trigger in cycle n+2. A level that stays high triggers only once.
- R6: A start event or direct trigger in cycle n raises `sync_out` in cycle n+1 when `delay_en`=0. It raises it in cycle n+1+D when `delay_en`=1, where D is `acq_dly`.
- R7: Each sync pulse is high for exactly PULSE_W consecutive clocks (3 by default).
- R8: With `single_mode`=1, the block disarms when the pulse ends. Later triggers and turn markers produce no pulse until `arm` is pulsed again.
- R9: With `single_mode`=0, a `turn_mark` received after a pulse ends starts the delay again, with the same timing as R6. A turn marker that falls inside a pulse is ignored.
- R10: `irq_dly_trig` is high for one cycle, in the cycle after the trigger or turn marker is accepted. `irq_dly_tc` is high for one cycle, in the first cycle of the pulse, and only when `delay_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF clock |
| rst_n | input | 1 | Synchronous active-low reset |
| turn_mark | input | 1 | Decoded turn-marker pulse |
| start_match | input | 1 | Decoded beam-sync start-event match pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| arm | input | 1 | Arm strobe; also reloads the turn scaler |
| start_sel | input | 2 | Start source: 00 event match, 10 turn scaler, others none |
| trig_sel | input | 2 | Trigger source: 0 pre-trigger, 1 external, 2 start, 3 none |
| single_mode | input | 1 | 1 single-shot, 0 repetitive |
| pretrig_en | input | 1 | Enables the pre-trigger counter |
| delay_en | input | 1 | Enables the delay timer |
| pretrig_dly | input | CNT_W | Pre-trigger count |
| acq_dly | input | CNT_W | Delay in RF periods |
| turn_scale | input | SCL_W | Turn scaler reload value |
| sync_out | output | 1 | Acquisition sync pulse |
| irq_dly_trig | output | 1 | Strobe: delay timer started |
| irq_dly_tc | output | 1 | Strobe: delay timer reached terminal count |

## Verification
Two functions can fall in the same cycle in repetitive mode: the end of a sync pulse and the turn marker that would start the next delay. The bench places a turn marker exactly on the last high cycle of a pulse. It then confirms that no pulse follows within a long window, and that the next turn marker produces a pulse at the delay given by R6. The delay timer's end and the first pulse cycle also coincide. The bench judges this by requiring that the terminal-count strobe falls on the rise cycle of every delayed pulse in the delay sweep.

// File: rtl/acq_sync_pkg.sv
// Shared codes for the acquisition sync generator.
package acq_sync_pkg;
    localparam logic [1:0] START_EVT    = 2'd0;
    localparam logic [1:0] START_NONE   = 2'd1;
    localparam logic [1:0] START_SCALER = 2'd2;

    localparam logic [1:0] TRIG_PRE   = 2'd0;
    localparam logic [1:0] TRIG_EXT   = 2'd1;
    localparam logic [1:0] TRIG_START = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DELAY,
        ST_PULSE,
        ST_WAIT_TURN
    } seq_state_t;
endpackage

// File: rtl/acq_ext_sync.sv
// Two-flop synchroniser for the external trigger, followed by a rising-edge detector.
// Assumes ext_in is asynchronous to clk. rise is high for one cycle.
module acq_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic s1, s2, s3;

    // Shift the input through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ext_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/acq_turn_scaler.sv
// Turn scaler: loaded on demand and decremented by each turn marker.
// A marker that finds the count at zero is reported and reloads the count.
module acq_turn_scaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SCL_W-1:0] load_val,
    input  logic             turn_mark,
    output logic             zero_hit
);
    logic [SCL_W-1:0] cnt;

    assign zero_hit = turn_mark && (cnt == '0);

    // Reload on load or on a zero hit; otherwise count turn markers down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (turn_mark) begin
            if (cnt == '0) cnt <= load_val;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/acq_pretrig.sv
// Pre-trigger counter. A start loads dly; fire is high in the cycle the count reaches zero,
// which is dly+1 cycles after the start. A new start restarts the count.
module acq_pretrig #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dly,
    output logic             fire
);
    logic             busy;
    logic [CNT_W-1:0] cnt;

    assign fire = busy && (cnt == '0);

    // Load on start; otherwise count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= dly;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/acq_delay_seq.sv
// Arm / delay / pulse sequencer. An accepted trigger (or, in repetitive mode, a turn
// marker) starts the delay timer. When the timer expires, a pulse PULSE_W cycles wide
// is driven. Single mode returns to idle after the pulse; repetitive mode waits for
// the next turn marker. Assumes trig and turn_mark are single-cycle pulses.
module acq_delay_seq
    import acq_sync_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PULSE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             single_mode,
    input  logic             delay_en,
    input  logic [CNT_W-1:0] dly,
    input  logic             trig,
    input  logic             turn_mark,
    output logic             sync_out,
    output logic             irq_trig,
    output logic             irq_tc
);
    localparam int PW_W = $clog2(PULSE_W + 1);

    seq_state_t      state;
    logic [CNT_W-1:0] dcnt;
    logic [PW_W-1:0]  pcnt;
    logic             go_delay;
    logic             use_dly;

    // Decide whether the delay timer starts this cycle and whether it is used.
    always_comb begin
        go_delay = ((state == ST_ARMED) && trig) ||
                   ((state == ST_WAIT_TURN) && turn_mark);
        use_dly  = delay_en && (dly != '0);
    end

    // Sequencer state, counters and interrupt strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dcnt     <= '0;
            pcnt     <= '0;
            irq_trig <= 1'b0;
            irq_tc   <= 1'b0;
        end else begin
            irq_trig <= 1'b0;
            irq_tc   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (arm) state <= ST_ARMED;
                end
                ST_ARMED, ST_WAIT_TURN: begin
                    if (go_delay) begin
                        irq_trig <= 1'b1;
                        if (use_dly) begin
                            state <= ST_DELAY;
                            dcnt  <= dly - 1'b1;
                        end else begin
                            state  <= ST_PULSE;
                            pcnt   <= PW_W'(PULSE_W - 1);
                            irq_tc <= delay_en;
                        end
                    end
                end
                ST_DELAY: begin
                    if (dcnt == '0) begin
                        state  <= ST_PULSE;
                        pcnt   <= PW_W'(PULSE_W - 1);
                        irq_tc <= 1'b1;
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (pcnt == '0) state <= single_mode ? ST_IDLE : ST_WAIT_TURN;
                    else            pcnt  <= pcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sync_out = (state == ST_PULSE);
endmodule

// File: rtl/acq_sync_gen.sv
// Top of the acquisition sync generator. Selects the start source and the trigger
// source, then hands the trigger to the delay/pulse sequencer. Assumes event inputs
// are single-cycle pulses on clk; ext_trig may be asynchronous.
module acq_sync_gen
    import acq_sync_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SCL_W   = 8,
    parameter int PULSE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_mark,
    input  logic             start_match,
    input  logic             ext_trig,
    input  logic             arm,
    input  logic [1:0]       start_sel,
    input  logic [1:0]       trig_sel,
    input  logic             single_mode,
    input  logic             pretrig_en,
    input  logic             delay_en,
    input  logic [CNT_W-1:0] pretrig_dly,
    input  logic [CNT_W-1:0] acq_dly,
    input  logic [SCL_W-1:0] turn_scale,
    output logic             sync_out,
    output logic             irq_dly_trig,
    output logic             irq_dly_tc
);
    logic scl_zero, ext_rise, pre_fire, pre_start;
    logic start_evt, trig;

    acq_turn_scaler #(.SCL_W(SCL_W)) u_scaler (
        .clk(clk), .rst_n(rst_n), .load(arm), .load_val(turn_scale),
        .turn_mark(turn_mark), .zero_hit(scl_zero)
    );

    acq_ext_sync u_ext (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_trig), .rise(ext_rise)
    );

    acq_pretrig #(.CNT_W(CNT_W)) u_pretrig (
        .clk(clk), .rst_n(rst_n), .start(pre_start), .dly(pretrig_dly), .fire(pre_fire)
    );

    // Choose the start event and the trigger from the two select fields.
    always_comb begin
        unique case (start_sel)
            START_EVT:    start_evt = start_match;
            START_SCALER: start_evt = scl_zero;
            default:      start_evt = 1'b0;
        endcase
        pre_start = start_evt && (trig_sel == TRIG_PRE) && pretrig_en;
        unique case (trig_sel)
            TRIG_PRE:   trig = pretrig_en ? pre_fire : start_evt;
            TRIG_EXT:   trig = ext_rise;
            TRIG_START: trig = start_evt;
            default:    trig = 1'b0;
        endcase
    end

    acq_delay_seq #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .single_mode(single_mode),
        .delay_en(delay_en), .dly(acq_dly), .trig(trig), .turn_mark(turn_mark),
        .sync_out(sync_out), .irq_trig(irq_dly_trig), .irq_tc(irq_dly_tc)
    );
endmodule

// File: rtl/acq_sync_gen_chk.sv
// Assertion checker for acq_sync_gen, bound to the top module.
module acq_sync_gen_chk #(
    parameter int PULSE_W = 3
) (
    input logic clk,
    input logic rst_n,
    input logic sync_out,
    input logic irq_dly_trig,
    input logic irq_dly_tc
);
    logic [7:0] run;

    // Count how many cycles the current pulse has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (sync_out) run <= run + 1'b1;
        else               run <= '0;
    end

    a_r7_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (run < 8'(PULSE_W)));

    a_r7_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |-> (run == 8'(PULSE_W)));

    a_r10_trig_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dly_trig |=> !irq_dly_trig);

    a_r10_tc_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dly_tc |=> !irq_dly_tc);

    a_r10_tc_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dly_tc |-> $rose(sync_out));

    a_r10_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> (irq_dly_tc || irq_dly_trig));
endmodule

bind acq_sync_gen acq_sync_gen_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_out(sync_out),
    .irq_dly_trig(irq_dly_trig), .irq_dly_tc(irq_dly_tc)
);

// File: tb/acq_sync_gen_bench.sv
module acq_sync_gen_bench;
    localparam int CNT_W = 16;
    localparam int SCL_W = 8;
    localparam int PW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic turn_mark = 0, start_match = 0, ext_trig = 0, arm = 0;
    logic [1:0] start_sel = 2'd0, trig_sel = 2'd2;
    logic single_mode = 1'b1, pretrig_en = 1'b0, delay_en = 1'b0;
    logic [CNT_W-1:0] pretrig_dly = '0, acq_dly = '0;
    logic [SCL_W-1:0] turn_scale = '0;
    logic sync_out, irq_dly_trig, irq_dly_tc;

    int cyc = 0, checks = 0, failures = 0;
    int rises = 0, rise_cyc = -1, last_w = 0, run = 0, trig_cyc = -1, tc_cyc = -1;
    logic prev_sync = 1'b0;

    always #4 clk = ~clk;

    acq_sync_gen #(.CNT_W(CNT_W), .SCL_W(SCL_W), .PULSE_W(PW)) u_acq_sync_gen (
        .clk(clk), .rst_n(rst_n), .turn_mark(turn_mark), .start_match(start_match),
        .ext_trig(ext_trig), .arm(arm), .start_sel(start_sel), .trig_sel(trig_sel),
        .single_mode(single_mode), .pretrig_en(pretrig_en), .delay_en(delay_en),
        .pretrig_dly(pretrig_dly), .acq_dly(acq_dly), .turn_scale(turn_scale),
        .sync_out(sync_out), .irq_dly_trig(irq_dly_trig), .irq_dly_tc(irq_dly_tc)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_out && !prev_sync) begin rises++; rise_cyc = cyc; end
            if (sync_out) run++;
            else if (prev_sync) begin last_w = run; run = 0; end
            if (irq_dly_trig) trig_cyc = cyc;
            if (irq_dly_tc) tc_cyc = cyc;
            prev_sync = sync_out;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
    endtask

    task automatic do_match(output int at);
        @(negedge clk); start_match = 1'b1; at = cyc; @(negedge clk); start_match = 1'b0;
    endtask

    task automatic do_turn(output int at);
        @(negedge clk); turn_mark = 1'b1; at = cyc; @(negedge clk); turn_mark = 1'b0;
    endtask

    task automatic turn_at(input int target);
        do @(negedge clk); while (cyc < target);
        turn_mark = 1'b1; @(negedge clk); turn_mark = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int at, r0, m;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 sync after reset", int'(sync_out), 0);
        check("R1 trig strobe after reset", int'(irq_dly_trig), 0);
        check("R1 tc strobe after reset", int'(irq_dly_tc), 0);
        do_match(at); idle(10);
        check("R1 no pulse before arm", rises, 0);

        // R6 R7 R10: direct start, delay sweep
        for (int d = 0; d <= 6; d++) begin
            delay_en = (d != 0); acq_dly = CNT_W'(d);
            do_arm(); idle(2);
            r0 = rises; do_match(at); idle(d + 10);
            check("R6 rise cycle", rise_cyc, at + 1 + d);
            check("R7 pulse width", last_w, PW);
            check("R8 one pulse", rises - r0, 1);
            check("R10 trig strobe cycle", trig_cyc, at + 1);
            if (d != 0) check("R10 tc on rise", tc_cyc, rise_cyc);
        end
        // R6 delay_en with zero delay gives tc with the pulse
        delay_en = 1'b1; acq_dly = '0; do_arm(); idle(2);
        do_match(at); idle(8);
        check("R6 zero delay rise", rise_cyc, at + 1);
        check("R10 tc zero delay", tc_cyc, at + 1);

        // R4: pre-trigger sweep
        trig_sel = 2'd0; pretrig_en = 1'b1; delay_en = 1'b1; acq_dly = CNT_W'(2);
        for (int p = 0; p <= 4; p++) begin
            pretrig_dly = CNT_W'(p);
            do_arm(); idle(2);
            do_match(at); idle(p + 12);
            check("R4 pretrig rise", rise_cyc, at + 1 + (p + 1) + 2);
        end
        pretrig_en = 1'b0; do_arm(); idle(2);
        do_match(at); idle(10);
        check("R4 pretrig bypass rise", rise_cyc, at + 1 + 2);

        // R5: external trigger sweep, level held high
        trig_sel = 2'd1;
        for (int d = 0; d <= 3; d++) begin
            delay_en = (d != 0); acq_dly = CNT_W'(d);
            do_arm(); idle(2);
            r0 = rises;
            @(negedge clk); ext_trig = 1'b1; at = cyc;
            idle(d + 12);
            check("R5 ext rise", rise_cyc, at + 3 + d);
            check("R5 single edge", rises - r0, 1);
            ext_trig = 1'b0; idle(4);
        end

        // R2: turn scaler sweep
        start_sel = 2'd2; trig_sel = 2'd2; delay_en = 1'b0;
        for (int l = 0; l <= 3; l++) begin
            turn_scale = SCL_W'(l);
            do_arm(); idle(2);
            r0 = rises;
            for (int k = 0; k < l; k++) begin do_turn(at); idle(6); end
            check("R2 scaler early", rises - r0, 0);
            do_turn(at); idle(8);
            check("R2 scaler rise", rise_cyc, at + 1);
        end

        // R2: no start source
        start_sel = 2'd1; do_arm(); idle(2);
        r0 = rises;
        do_match(at); do_turn(at); do_turn(at); idle(8);
        check("R2 start none", rises - r0, 0);

        // R3: no trigger source
        start_sel = 2'd0; trig_sel = 2'd3;
        do_match(at); idle(8);
        check("R3 trig none", rises - r0, 0);

        // R8: single mode disarms
        trig_sel = 2'd2;
        do_match(at); idle(8);
        check("R3 start trig still armed", rise_cyc, at + 1);
        r0 = rises;
        do_match(at); do_turn(at); idle(8);
        check("R8 disarmed after pulse", rises - r0, 0);
        do_arm(); idle(2); do_match(at); idle(8);
        check("R8 rearm works", rise_cyc, at + 1);

        // R9: repetitive mode, turn marker on the last pulse cycle is ignored
        single_mode = 1'b0; delay_en = 1'b1; acq_dly = CNT_W'(4);
        do_arm(); idle(2);
        do_match(at);
        m = at + 1 + 4;
        turn_at(m + PW - 1);
        idle(20);
        check("R9 first rise", rise_cyc, m);
        check("R9 overlap turn ignored", rise_cyc, m);
        do_turn(at); idle(12);
        check("R9 repeat rise", rise_cyc, at + 1 + 4);
        check("R10 repeat trig strobe", trig_cyc, at + 1);
        do_turn(at); idle(12);
        check("R9 second repeat", rise_cyc, at + 5);
        single_mode = 1'b1;
        do_turn(at); idle(12);
        check("R9 last repeat", rise_cyc, at + 5);
        r0 = rises;
        do_turn(at); idle(12);
        check("R8 stop after single", rises - r0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule